// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) and returns their full product of `2*WIDTH` bits. It spends one clock cycle per multiplier bit and shares one `WIDTH`-bit adder across all of them. It has no separate register for the multiplier. The multiplier is loaded into the lower half of a double-width product register, and the upper half is cleared. On each step, bit 0 of that register decides whether the multiplicand is added into the upper half. The whole register then moves one place to the right, and the adder's carry-out enters the top bit.

The host drives the operands and pulses `start` while the block is idle. The controller has three states:

- `ST_IDLE`: waiting for work.
- `ST_RUN`: one add-and-shift step per cycle.
- `ST_DONE`: a single-cycle completion state.

It has five named transitions:

- T_HOLD: `ST_IDLE` stays in `ST_IDLE` without `start`.
- T_ACCEPT: `ST_IDLE` goes to `ST_RUN` on `start`, and the operands are loaded in the same edge.
- T_STEP: `ST_RUN` stays in `ST_RUN` while steps remain.
- T_FINISH: `ST_RUN` goes to `ST_DONE` after the last step.
- T_RETURN: `ST_DONE` goes to `ST_IDLE` unconditionally.

`done` is high only in `ST_DONE`. `busy` is high in `ST_RUN` and in `ST_DONE`.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `product` is all zeros until a start is accepted.
- R2: A `start` sampled high while `busy` is 0 is accepted at that edge. From the next cycle `busy` is 1, and `product` equals the multiplier in bits [WIDTH-1:0] with zeros in bits [2*WIDTH-1:WIDTH].
- R3: When `done` is 1, `product` equals the unsigned product of the multiplicand and multiplier that were captured at acceptance.
- R4: `done` rises exactly WIDTH clock edges after the edge that accepted `start`: one load edge followed by WIDTH step edges.
- R5: `done` is high for exactly one cycle per accepted start. `busy` falls to 0 in the cycle after `done`.
- R6: A `start` sampled while `busy` is 1, including the `done` cycle, is ignored. The running operation keeps its result and timing, and no extra `done` is produced.
- R7: `product` keeps its value from the `done` cycle until the next start is accepted.
- R8: The carry-out of the upper-half addition is kept in the top product bit. With both operands all ones, the product is 0xFFFFFFFE00000001 when WIDTH is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; sampled only while idle |
| mcand | input | WIDTH | Multiplicand operand |
| mplier | input | WIDTH | Multiplier operand |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion strobe |
| product | output | 2*WIDTH | Product register contents |

## Verification
The bench builds the block with its default WIDTH of 32, so the multiplier takes its full 32 steps. At this width, operands at the extremes (all ones, the top bit alone, zero, one) exercise the carry path into bit 63 and the longest latency. A long stream of pseudo-random operand pairs runs back to back, with start pulses placed mid-operation and in the done cycle. These show that a busy multiplier cannot be disturbed and that the held result survives idle periods.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/mul_adder.sv
// Ripple-carry adder built from per-bit full-adder cells.
module mul_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = op_a[i] ^ op_b[i] ^ carry[i];
        assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & (op_a[i] ^ op_b[i]));
    end

    assign cout = carry[WIDTH];

endmodule

// File: rtl/mul_datapath.sv
// Multiplicand register plus double-width product register that also
// carries the not-yet-consumed multiplier bits in its lower half.
module mul_datapath #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] upper_sum;
    logic             upper_cout;

    // Bit 0 of the product register is the current multiplier bit.
    always_comb begin
        addend = prod_q[0] ? mcand_q : '0;
    end

    mul_adder #(.WIDTH(WIDTH)) u_adder (
        .op_a (prod_q[PW-1:WIDTH]),
        .op_b (addend),
        .sum  (upper_sum),
        .cout (upper_cout)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {upper_cout, upper_sum, prod_q[WIDTH-1:1]};
        end
    end

    assign product = prod_q;

endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: idle, WIDTH step cycles, one-cycle completion.
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mul_state_e       state_q;
    mul_state_e       state_d;
    logic [CW-1:0]    step_cnt;
    logic             last_step;

    assign last_step = (step_cnt == LAST_STEP);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
        end else if (load) begin
            step_cnt <= '0;
        end else if (step && !last_step) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;      // T_ACCEPT, else T_HOLD
            ST_RUN:  if (last_step) state_d = ST_DONE; // T_FINISH, else T_STEP
            ST_DONE: state_d = ST_IDLE;                // T_RETURN
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    logic load;
    logic step;

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .product   (product)
    );

endmodule

// File: rtl/shiftadd_mul_checker.sv
module shiftadd_mul_checker #(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    localparam int RCW = $clog2(WIDTH + 1) + 1;

    logic [WIDTH-1:0] cap_a;
    logic [WIDTH-1:0] cap_b;
    logic [RCW-1:0]   run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= '0;
        end else begin
            if (start && !busy) begin
                cap_a <= mcand;
                cap_b <= mplier;
            end
            if (!busy) run_cnt <= '0;
            else if (!done) run_cnt <= run_cnt + 1'b1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && product == '0));

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && product == {{WIDTH{1'b0}}, $past(mplier)}));

    a_r3_product: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ({{WIDTH{1'b0}}, cap_a} * {{WIDTH{1'b0}}, cap_b})));

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == RCW'(WIDTH)));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r6_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind shiftadd_mul shiftadd_mul_checker #(.WIDTH(WIDTH)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/shiftadd_mul_test.sv
`timescale 1ns/1ps
module shiftadd_mul_test;

    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [2*W-1:0] exp_q[$];
    int             expc_q[$];
    logic           prev_done = 1'b0;
    logic [2*W-1:0] last_prod = '0;
    logic [W-1:0]   seed = 32'h1234_5678;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    shiftadd_mul #(.WIDTH(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input bit ok, input string req,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops scoreboard on done, checks pulse width and hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                check(!done && !busy, "R5 done single cycle then idle",
                      {62'd0, busy, done}, '0);
                check(product === last_prod, "R7 product held after done",
                      product, last_prod);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 spurious done", {63'd0, done}, '0);
                end else begin
                    logic [2*W-1:0] e;
                    int ec;
                    e  = exp_q.pop_front();
                    ec = expc_q.pop_front();
                    check(product === e, "R3 product value", product, e);
                    check(cyc == ec, "R4 done latency", 64'(cyc), 64'(ec));
                end
                last_prod = product;
            end
            prev_done = done;
        end
    end

    // Driver: starts one multiplication and pushes the expectation.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit poke_busy, input bit poke_done);
        int c0;
        logic [2*W-1:0] e;
        while (busy) @(negedge clk);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c0 = cyc;
        check(busy === 1'b1, "R2 busy after accept", {63'd0, busy}, 64'd1);
        check(product === {{W{1'b0}}, b}, "R2 loaded register", product, {{W{1'b0}}, b});
        e = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        exp_q.push_back(e);
        expc_q.push_back(c0 + W);
        if (poke_busy) begin
            repeat (9) @(negedge clk);
            mcand  = ~a;
            mplier = b ^ 32'h5A5A_A5A5;
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b1 && !done, "R6 start while running ignored",
                  {62'd0, busy, done}, 64'd2);
        end
        while (!done) @(negedge clk);
        if (a == '1 && b == '1)
            check(product === 64'hFFFF_FFFE_0000_0001, "R8 carry into top bit",
                  product, 64'hFFFF_FFFE_0000_0001);
        if (poke_done) begin
            mcand  = 32'hDEAD_BEEF;
            mplier = 32'h0000_0003;
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b0, "R6 start in done cycle ignored", {63'd0, busy}, '0);
            check(product === e, "R6 result kept", product, e);
        end else begin
            @(negedge clk);
        end
    endtask

    task automatic idle_hold(input int n);
        logic [2*W-1:0] p;
        p = product;
        repeat (n) @(negedge clk);
        check(product === p && !busy, "R7 product held while idle", product, p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && product === '0, "R1 state during reset",
              product | {62'd0, busy, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && product === '0, "R1 state after reset",
              product | {62'd0, busy, done}, '0);

        run_op(32'd3, 32'd5, 1'b0, 1'b0);
        idle_hold(6);
        run_op(32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_op(32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run_op(32'd1, 32'hCAFE_F00D, 1'b0, 1'b0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b0);
        run_op(32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 1'b1);
        idle_hold(10);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);

        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            b = seed;
            run_op(a, b, (i % 5) == 2, (i % 7) == 3);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 every accepted start completed",
              64'(exp_q.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule